// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block receives characters from an asynchronous serial line. A two-stage synchronizer brings the line into the system clock domain. The block runs from the system clock, with a tick enable at sixteen times the bit rate; the tick comes from outside. A falling edge on an idle line starts a character. Each new start edge restarts the bit timing, so rate mismatch can only build up within one character and never carries into the next. The longest character is 12 bits (start, 8 data, parity, 2 stop), and its final stop bit is still voted correctly while accumulated drift stays below about a quarter of a bit. For the default 10-bit frame, that is a rate mismatch of about 2.5%.

Within every bit, the block takes three samples: just before, at and just after the bit centre. It settles the bit value by majority vote. Any disagreement between the three samples is not hidden. It sets a noise flag for the whole character.

The output stream is strobe-only. `rx_valid` rises for exactly one clock with the data and the three error flags. There is no ready input, so the block cannot be held back. A consumer must take the character in the strobe cycle, and the outputs then hold until the next character completes.

The character format is sampled from the configuration pins at each start edge. The format covers data length, parity enable, parity sense and stop-bit count.

Top module: `serial_rx_oversample`

## Requirements
- R1: After reset, `rx_valid`, `rx_data` and all three error flags are zero.
- R2: A character begins on the first tick that sees the synchronized line low after a tick that saw it high; that tick is position 0. Each bit lasts 16 ticks from there, and its value is the majority of the samples taken at positions 7, 8 and 9 of that bit.
- R3: If the start bit votes high, the block drops the character, produces no `rx_valid`, and waits for a fresh falling edge.
- R4: Data arrives least-significant bit first. `cfg_len` selects 5, 6, 7 or 8 data bits (codes 0, 1, 2, 3), and unused upper bits of `rx_data` read zero.
- R5: With `cfg_parity_en` high, one parity bit follows the data. When `cfg_parity_odd` is 0, the data and parity bits together must hold an even number of ones; when it is 1, an odd number. A mismatch sets `rx_err_parity`. With parity off, `rx_err_parity` is zero.
- R6: `cfg_stop2` selects one (0) or two (1) stop bits. `rx_err_frame` is set if any stop bit votes low.
- R7: `rx_err_noise` is set if, in any bit of the character, the three samples do not all agree. The voted value is still delivered.
- R8: `rx_valid` is a single-cycle pulse issued after the last stop bit is voted. `rx_data` and all flags are valid in that cycle and hold until the next pulse.
- R9: Characters sent back to back, with the next start bit directly after the last stop bit, are all received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| tick16 | input | 1 | Enable pulse at 16x the bit rate |
| rxd | input | 1 | Asynchronous serial line, idle high |
| cfg_len | input | 2 | Data length code: 0..3 selects 5..8 bits |
| cfg_parity_en | input | 1 | Parity bit present |
| cfg_parity_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_stop2 | input | 1 | 1 = two stop bits |
| rx_valid | output | 1 | One-cycle character strobe |
| rx_data | output | 8 | Received data, right aligned |
| rx_err_frame | output | 1 | A stop bit was low |
| rx_err_parity | output | 1 | Parity mismatch |
| rx_err_noise | output | 1 | Sample disagreement within a bit |

## Verification
The bench injects a one-tick glitch on the centre sample of a data bit. A design that sampled once would return corrupted data; one that voted silently would lose the noise flag. A start pulse only three ticks long must produce nothing, or a phantom character reaches the scoreboard. A low second stop bit must raise the framing flag, which catches a design that reports after the first stop. Back-to-back characters of different lengths, with both parity senses, expose timing that does not re-align on each start edge, and unused upper data bits that are left uncleared.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= {STAGES{RST_VAL}};
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/serial_rx_sampler.sv
module serial_rx_sampler #(
  parameter int OSR       = 16,
  parameter int POS_EARLY = 7,
  parameter int POS_MID   = 8,
  parameter int POS_LATE  = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line,
  input  logic restart,
  input  logic run,
  output logic vote_stb,
  output logic vote_bit,
  output logic vote_noise
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] P_E   = CW'(POS_EARLY);
  localparam logic [CW-1:0] P_M   = CW'(POS_MID);
  localparam logic [CW-1:0] P_L   = CW'(POS_LATE);
  localparam logic [CW-1:0] P_TOP = CW'(OSR - 1);

  logic [CW-1:0] pos;
  logic s_early, s_mid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos        <= '0;
      s_early    <= 1'b1;
      s_mid      <= 1'b1;
      vote_stb   <= 1'b0;
      vote_bit   <= 1'b1;
      vote_noise <= 1'b0;
    end else begin
      vote_stb <= 1'b0;
      if (tick) begin
        if (restart) begin
          pos <= CW'(1);
        end else if (run) begin
          pos <= (pos == P_TOP) ? '0 : pos + CW'(1);
          if (pos == P_E) s_early <= line;
          if (pos == P_M) s_mid   <= line;
          if (pos == P_L) begin
            vote_stb   <= 1'b1;
            vote_bit   <= (s_early & s_mid) | (s_early & line) | (s_mid & line);
            vote_noise <= !((s_early == s_mid) && (s_mid == line));
          end
        end
      end
    end
  end

  AST_VOTE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    vote_stb |=> !vote_stb); // R2
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_parity_en,
  input  logic              cfg_parity_odd,
  input  logic              cfg_stop2,
  input  logic              vote_stb,
  input  logic              vote_bit,
  input  logic              vote_noise,
  output logic              restart,
  output logic              run,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_err_frame,
  output logic              rx_err_parity,
  output logic              rx_err_noise
);
  localparam int MIN_BITS = DATA_W - (2 ** LEN_W) + 1;
  localparam int NW       = $clog2(DATA_W + 1);
  localparam int IW       = $clog2(DATA_W);

  rx_state_e         state;
  logic              line_prev;
  logic [NW-1:0]     nbits_q;
  logic              par_en_q, par_odd_q, stop2_q;
  logic [IW-1:0]     idx;
  logic [DATA_W-1:0] shreg;
  logic              par_bit, stop_seen, noise_acc, frame_acc;
  logic              last_data;

  assign restart   = tick && (state == ST_IDLE) && line_prev && !line;
  assign run       = (state != ST_IDLE);
  assign last_data = (NW'(idx) == nbits_q - NW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      line_prev     <= 1'b1;
      nbits_q       <= NW'(DATA_W);
      par_en_q      <= 1'b0;
      par_odd_q     <= 1'b0;
      stop2_q       <= 1'b0;
      idx           <= '0;
      shreg         <= '0;
      par_bit       <= 1'b0;
      stop_seen     <= 1'b0;
      noise_acc     <= 1'b0;
      frame_acc     <= 1'b0;
      rx_valid      <= 1'b0;
      rx_data       <= '0;
      rx_err_frame  <= 1'b0;
      rx_err_parity <= 1'b0;
      rx_err_noise  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (tick) line_prev <= line;
      if (restart) begin
        state     <= ST_START;
        nbits_q   <= NW'(MIN_BITS) + NW'(cfg_len);
        par_en_q  <= cfg_parity_en;
        par_odd_q <= cfg_parity_odd;
        stop2_q   <= cfg_stop2;
        idx       <= '0;
        shreg     <= '0;
        par_bit   <= 1'b0;
        stop_seen <= 1'b0;
        noise_acc <= 1'b0;
        frame_acc <= 1'b0;
      end else if (vote_stb) begin
        noise_acc <= noise_acc | vote_noise;
        unique case (state)
          ST_START: state <= vote_bit ? ST_IDLE : ST_DATA;
          ST_DATA: begin
            shreg[idx] <= vote_bit;
            idx        <= idx + IW'(1);
            if (last_data) state <= par_en_q ? ST_PAR : ST_STOP;
          end
          ST_PAR: begin
            par_bit <= vote_bit;
            state   <= ST_STOP;
          end
          ST_STOP: begin
            if (!vote_bit) frame_acc <= 1'b1;
            if (stop2_q && !stop_seen) begin
              stop_seen <= 1'b1;
            end else begin
              state         <= ST_IDLE;
              rx_valid      <= 1'b1;
              rx_data       <= shreg;
              rx_err_frame  <= frame_acc | !vote_bit;
              rx_err_parity <= par_en_q & ((^shreg) ^ par_bit ^ par_odd_q);
              rx_err_noise  <= noise_acc | vote_noise;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R8
  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ((rx_data >> nbits_q) == '0)); // R4
  AST_PARITY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !par_en_q) |-> !rx_err_parity); // R5
  AST_FALSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_START && vote_stb && vote_bit) |=> (state == ST_IDLE && !rx_valid)); // R3
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> (rx_valid || $stable(rx_data))); // R8
endmodule

// File: rtl/serial_rx_oversample.sv
module serial_rx_oversample #(
  parameter int OSR         = 16,
  parameter int DATA_W      = 8,
  parameter int LEN_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxd,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_parity_en,
  input  logic              cfg_parity_odd,
  input  logic              cfg_stop2,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_err_frame,
  output logic              rx_err_parity,
  output logic              rx_err_noise
);
  localparam int MID = OSR / 2;

  logic line_s, restart, run;
  logic vote_stb, vote_bit, vote_noise;

  serial_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(line_s)
  );

  serial_rx_sampler #(
    .OSR(OSR), .POS_EARLY(MID - 1), .POS_MID(MID), .POS_LATE(MID + 1)
  ) samp_i (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .line(line_s),
    .restart(restart), .run(run),
    .vote_stb(vote_stb), .vote_bit(vote_bit), .vote_noise(vote_noise)
  );

  serial_rx_frame #(.DATA_W(DATA_W), .LEN_W(LEN_W)) frame_i (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .line(line_s),
    .cfg_len(cfg_len), .cfg_parity_en(cfg_parity_en),
    .cfg_parity_odd(cfg_parity_odd), .cfg_stop2(cfg_stop2),
    .vote_stb(vote_stb), .vote_bit(vote_bit), .vote_noise(vote_noise),
    .restart(restart), .run(run),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_err_frame(rx_err_frame), .rx_err_parity(rx_err_parity),
    .rx_err_noise(rx_err_noise)
  );
endmodule

// File: tb/serial_rx_oversample_tb_top.sv
`timescale 1ns/1ps
module serial_rx_oversample_tb_top;
  localparam int TDIV    = 4;
  localparam int BIT_CLK = 16 * TDIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16 = 1'b0;
  logic rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic cfg_parity_en = 1'b0, cfg_parity_odd = 1'b0, cfg_stop2 = 1'b0;
  logic rx_valid, rx_err_frame, rx_err_parity, rx_err_noise;
  logic [7:0] rx_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [7:0] d;
    logic fe, pe, ne;
  } exp_t;
  exp_t exq[$];
  string tagq[$];

  always #2.5 clk = ~clk;

  serial_rx_oversample dut_i (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .cfg_len(cfg_len), .cfg_parity_en(cfg_parity_en),
    .cfg_parity_odd(cfg_parity_odd), .cfg_stop2(cfg_stop2),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_err_frame(rx_err_frame), .rx_err_parity(rx_err_parity),
    .rx_err_noise(rx_err_noise)
  );

  initial begin : tick_gen
    int c = 0;
    forever begin
      @(negedge clk);
      c = (c + 1) % TDIV;
      tick16 = (c == 0);
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic hold(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  // nb = 5..8 data bits; glitch_bit = frame bit index to glitch, -1 for none
  task automatic send_char(input logic [7:0] d, input int nb, input bit pen,
                           input bit podd, input bit two, input bit bad_par,
                           input bit bad_stop, input int glitch_bit, input string tag);
    logic [11:0] bits;
    logic [7:0] md;
    logic p;
    int n;
    exp_t e;
    md = d & 8'((9'h1 << nb) - 1);
    p  = (^md) ^ podd ^ bad_par;
    cfg_len = 2'(nb - 5);
    cfg_parity_en = pen;
    cfg_parity_odd = podd;
    cfg_stop2 = two;
    e.d = md; e.fe = bad_stop; e.pe = pen & bad_par; e.ne = (glitch_bit >= 0);
    exq.push_back(e);
    tagq.push_back(tag);
    n = 0;
    bits[n++] = 1'b0;
    for (int i = 0; i < nb; i++) bits[n++] = md[i];
    if (pen) bits[n++] = p;
    if (two) bits[n++] = 1'b1;
    bits[n++] = !bad_stop;
    for (int k = 0; k < n; k++) begin
      if (k == glitch_bit) begin
        hold(bits[k], 32);
        hold(!bits[k], TDIV);
        hold(bits[k], BIT_CLK - 32 - TDIV);
      end else begin
        hold(bits[k], BIT_CLK);
      end
    end
  endtask

  // monitor: pops the scoreboard on each strobe
  initial begin : monitor
    exp_t e;
    string t;
    forever begin
      @(negedge clk);
      if (rst_n && rx_valid) begin
        if (exq.size() == 0) begin
          check(1'b0, "R3 unexpected character", int'(rx_data), 0);
        end else begin
          e = exq.pop_front();
          t = tagq.pop_front();
          check(rx_data == e.d, {t, " data R4"}, int'(rx_data), int'(e.d));
          check(rx_err_frame == e.fe, {t, " frame R6"}, int'(rx_err_frame), int'(e.fe));
          check(rx_err_parity == e.pe, {t, " parity R5"}, int'(rx_err_parity), int'(e.pe));
          check(rx_err_noise == e.ne, {t, " noise R7"}, int'(rx_err_noise), int'(e.ne));
        end
        @(negedge clk);
        check(!rx_valid, "R8 strobe width", int'(rx_valid), 0);
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin : driver
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rx_valid == 1'b0, "R1 valid", int'(rx_valid), 0);
    check(rx_data == 8'h00, "R1 data", int'(rx_data), 0);
    check(rx_err_frame == 1'b0, "R1 frame", int'(rx_err_frame), 0);
    check(rx_err_parity == 1'b0, "R1 parity", int'(rx_err_parity), 0);
    check(rx_err_noise == 1'b0, "R1 noise", int'(rx_err_noise), 0);
    hold(1'b1, BIT_CLK);

    // R2 default frame, 8N1
    send_char(8'hA5, 8, 0, 0, 0, 0, 0, -1, "R2 8N1");
    hold(1'b1, BIT_CLK);
    // R3 false start: 3 ticks low, then a real character
    hold(1'b0, 3 * TDIV);
    hold(1'b1, 3 * BIT_CLK);
    send_char(8'h3C, 8, 0, 0, 0, 0, 0, -1, "R3 after glitch");
    // R9 back to back, mixed lengths and parity senses (R4, R5)
    send_char(8'hFF, 5, 0, 0, 0, 0, 0, -1, "R9 R4 5bit");
    send_char(8'h9B, 7, 1, 0, 0, 0, 0, -1, "R9 R5 7E1");
    send_char(8'h6E, 6, 1, 1, 0, 0, 0, -1, "R9 R5 6O1");
    send_char(8'h01, 8, 1, 1, 1, 0, 0, -1, "R9 R6 8O2");
    // R5 parity mismatch, even and odd
    send_char(8'h5A, 8, 1, 0, 0, 1, 0, -1, "R5 bad even");
    send_char(8'h80, 8, 1, 1, 0, 1, 0, -1, "R5 bad odd");
    // R7 glitch on a data bit centre
    send_char(8'h55, 8, 0, 0, 0, 0, 0, 3, "R7 glitch");
    send_char(8'hC3, 8, 1, 0, 0, 0, 0, 9, "R7 glitch parity");
    // R6 framing, one stop bit then two stop bits with the second low
    send_char(8'h42, 8, 0, 0, 0, 0, 1, -1, "R6 bad stop");
    hold(1'b1, 2 * BIT_CLK);
    send_char(8'h24, 8, 0, 0, 1, 0, 1, -1, "R6 bad 2nd stop");
    hold(1'b1, 2 * BIT_CLK);
    send_char(8'h00, 8, 0, 0, 0, 0, 0, -1, "R2 zero");
    hold(1'b1, 4 * BIT_CLK);
    check(exq.size() == 0, "R8 missing characters", exq.size(), 0);
    finish_run();
  end
endmodule